// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters on an asynchronous serial line. A host places a character of 7, 8 or 9 bits into a one-entry holding buffer with a write strobe. When the line is free and the start conditions hold, the character moves into a separate shift register. It goes out framed by a low start bit, followed by the data least significant bit first, an optional odd or even parity bit, and one or two high stop bits. Because the buffer is released as soon as a character enters the shift register, the host can queue the next character while the current one is on the line. Consecutive frames then follow each other with no idle gap.

The bit rate is derived from a selectable source clock: the system clock, the system clock divided by 8 or by 32, or rising edges of an external clock input. A programmable divisor n stretches each bit to 16 × (n+1) source cycles. A frame can be held back by an active-low clear-to-send input. That input is synchronized and is looked at only between frames. A one-cycle interrupt pulse is raised either when a character is taken from the buffer or when the last stop bit of a frame has been sent.

Top module: `uart_dbuf_tx`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1, tx_busy is 0 and irq is 0. The line stays at 1 whenever no frame is being sent.
- R2: A frame is one start bit at 0, then the data bits least significant bit first, then the stop bits at 1. cfg_char_len selects 0 = 7 bits, 1 = 8 bits, 2 = 9 bits, taken from the low bits of wr_data.
- R3: cfg_parity selects 0 = no parity bit, 1 = even (the parity bit makes the count of ones in data plus parity even), 2 = odd. The parity bit is sent right after the last data bit.
- R4: Each bit lasts 16 × (cfg_div+1) source cycles. cfg_src_sel selects 0 = system clock, 1 = system clock / 8, 2 = system clock / 32, 3 = rising edges of ext_clk.
- R5: cfg_two_stop = 0 gives one stop bit and 1 gives two stop bits.
- R6: A frame starts only when tx_en is 1, the buffer holds a character and, if cfg_cts_en is 1, cts_n is low. cts_n is sampled only between frames, so raising it during a frame does not shorten that frame.
- R7: buf_empty goes to 1 in the cycle the character moves into the shift register and goes to 0 on a write. A character written while a frame is being sent starts at the very next bit boundary after the current frame, with no idle bit between.
- R8: irq is a one-cycle pulse. With cfg_irq_sel = 0 it comes in the cycle the buffer is loaded into the shift register, which is the cycle txd drops for the start bit. With cfg_irq_sel = 1 it comes at the end of the last stop bit.
- R9: Clearing tx_en during a frame lets that frame finish. After that the line stays high and a buffered character waits until tx_en is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Character to send |
| tx_en | input | 1 | Transmit enable |
| cfg_src_sel | input | 2 | Source clock select |
| cfg_div | input | DIV_W | Bit-time divisor n |
| cfg_char_len | input | 2 | Character length select |
| cfg_parity | input | 2 | Parity mode |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| cfg_cts_en | input | 1 | Gate frame start on cts_n |
| cfg_irq_sel | input | 1 | Interrupt point select |
| ext_clk | input | 1 | External source clock |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial output |
| buf_empty | output | 1 | Holding buffer free |
| tx_busy | output | 1 | A frame is being sent |
| irq | output | 1 | Interrupt pulse |

## Verification
Frames are sent with several combinations of length, parity and stop count. Data values are chosen so that a wrong bit order, a missing high data bit, a wrong parity sense or a missing stop bit each give a different captured frame. The bit rate is measured from the length of a start bit for each source setting, which shows whether the divide-by-8, divide-by-32, external-edge and divisor paths are chosen correctly. Back-to-back writes, clear-to-send held high or raised mid-frame, and transmit enable dropped mid-frame show that gating acts only between frames. Both interrupt points are checked to the exact cycle.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int DATA_MAX  = 9;
  localparam int FRAME_MAX = 13;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  typedef enum logic [1:0] {
    SRC_FAST  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_EXT   = 2'd3
  } src_sel_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_t;

  typedef enum logic [1:0] {
    LEN_7 = 2'd0,
    LEN_8 = 2'd1,
    LEN_9 = 2'd2,
    LEN_X = 2'd3
  } char_len_t;
endpackage

// File: rtl/utx_sync.sv
module utx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= {STAGES{RST_VAL}};
    else     pipe_q <= {pipe_q[STAGES-2:0], d};
  end

  assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/utx_baud.sv
module utx_baud
  import utx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       src_sel,
  input  logic [DIV_W-1:0] div_n,
  input  logic             ext_rise,
  output logic             bit_tick
);
  localparam int OVS_W = $clog2(OVS);
  localparam int PRE_W = 5;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_used;
  logic             src_tick;
  logic [DIV_W-1:0] div_q;
  logic [OVS_W-1:0] ovs_q;

  always_comb begin
    pre_lim  = (src_sel == SRC_DIV8) ? PRE_W'(7) : PRE_W'(31);
    pre_used = (src_sel == SRC_DIV8) || (src_sel == SRC_DIV32);
    case (src_sel)
      SRC_FAST: src_tick = 1'b1;
      SRC_EXT:  src_tick = ext_rise;
      default:  src_tick = (pre_q >= pre_lim);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= '0;
      div_q    <= '0;
      ovs_q    <= '0;
      bit_tick <= 1'b0;
    end else begin
      if (pre_used) pre_q <= (pre_q >= pre_lim) ? '0 : pre_q + 1'b1;
      else          pre_q <= '0;
      bit_tick <= src_tick && (div_q == '0) && (ovs_q == OVS_W'(OVS - 1));
      if (src_tick) begin
        if (div_q == '0) begin
          div_q <= div_n;
          ovs_q <= (ovs_q == OVS_W'(OVS - 1)) ? '0 : ovs_q + 1'b1;
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R4
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_tick,
  input  logic                wr_stb,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic [1:0]          char_len,
  input  logic [1:0]          parity,
  input  logic                two_stop,
  input  logic                tx_en,
  input  logic                cts_en,
  input  logic                cts_sync,
  input  logic                irq_sel,
  output logic                txd,
  output logic                buf_empty,
  output logic                busy,
  output logic                irq
);
  logic [DATA_MAX-1:0]  hold_q;
  logic                 empty_q;
  logic [FRAME_MAX-1:0] shreg_q;
  logic [CNT_W-1:0]     remain_q;
  logic                 busy_q;
  logic                 txd_q;
  logic                 irq_q;

  logic [FRAME_MAX-1:0] frame_bits;
  logic [CNT_W-1:0]     frame_len;
  int                   dlen;
  logic                 par_acc;
  logic                 start_ok;
  logic                 last_bit;

  // frame assembly from the holding buffer
  always_comb begin
    case (char_len)
      LEN_7:   dlen = 7;
      LEN_9:   dlen = 9;
      default: dlen = 8;
    endcase
    frame_bits    = '1;
    frame_bits[0] = 1'b0;
    par_acc       = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < dlen) begin
        frame_bits[1 + i] = hold_q[i];
        par_acc           = par_acc ^ hold_q[i];
      end
    end
    frame_len = CNT_W'(1 + dlen + (two_stop ? 2 : 1));
    if (parity == PAR_EVEN || parity == PAR_ODD) begin
      frame_bits[1 + dlen] = (parity == PAR_ODD) ? ~par_acc : par_acc;
      frame_len            = frame_len + 1'b1;
    end
  end

  assign start_ok = tx_en && !empty_q && (!cts_en || !cts_sync);
  assign last_bit = !busy_q || (remain_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      empty_q  <= 1'b1;
      shreg_q  <= '1;
      remain_q <= '0;
      busy_q   <= 1'b0;
      txd_q    <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (bit_tick) begin
        if (!last_bit) begin
          shreg_q  <= {1'b1, shreg_q[FRAME_MAX-1:1]};
          txd_q    <= shreg_q[1];
          remain_q <= remain_q - 1'b1;
        end else begin
          if (busy_q && irq_sel) irq_q <= 1'b1;
          if (start_ok) begin
            shreg_q  <= frame_bits;
            txd_q    <= frame_bits[0];
            remain_q <= frame_len;
            busy_q   <= 1'b1;
            empty_q  <= 1'b1;
            if (!irq_sel) irq_q <= 1'b1;
          end else begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
          end
        end
      end
      if (wr_stb) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
      end
    end
  end

  assign txd       = txd_q;
  assign buf_empty = empty_q;
  assign busy      = busy_q;
  assign irq       = irq_q;

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !txd_q); // R2
  AST_STOP_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy_q && remain_q == CNT_W'(1)) |-> txd_q); // R5
  AST_START_GATE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> ($past(tx_en) && (!$past(cts_en) || !$past(cts_sync)))); // R6
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> (empty_q || $past(wr_stb))); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q); // R8
endmodule

// File: rtl/uart_dbuf_tx.sv
module uart_dbuf_tx
  import utx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic                tx_en,
  input  logic [1:0]          cfg_src_sel,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_char_len,
  input  logic [1:0]          cfg_parity,
  input  logic                cfg_two_stop,
  input  logic                cfg_cts_en,
  input  logic                cfg_irq_sel,
  input  logic                ext_clk,
  input  logic                cts_n,
  output logic                txd,
  output logic                buf_empty,
  output logic                tx_busy,
  output logic                irq
);
  logic ext_s, ext_d, ext_rise;
  logic cts_s;
  logic bit_tick;

  utx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) ext_sync_i (
    .clk(clk), .rst(rst), .d(ext_clk), .q(ext_s));

  utx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) cts_sync_i (
    .clk(clk), .rst(rst), .d(cts_n), .q(cts_s));

  always_ff @(posedge clk) begin
    if (rst) ext_d <= 1'b0;
    else     ext_d <= ext_s;
  end
  assign ext_rise = ext_s && !ext_d;

  utx_baud #(.DIV_W(DIV_W), .OVS(OVS)) baud_i (
    .clk(clk), .rst(rst), .src_sel(cfg_src_sel), .div_n(cfg_div),
    .ext_rise(ext_rise), .bit_tick(bit_tick));

  utx_shifter shift_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick),
    .wr_stb(wr_stb), .wr_data(wr_data),
    .char_len(cfg_char_len), .parity(cfg_parity), .two_stop(cfg_two_stop),
    .tx_en(tx_en), .cts_en(cfg_cts_en), .cts_sync(cts_s), .irq_sel(cfg_irq_sel),
    .txd(txd), .buf_empty(buf_empty), .busy(tx_busy), .irq(irq));

  AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
    !tx_busy |-> txd); // R1
endmodule

// File: tb/uart_dbuf_tx_tb.sv
`timescale 1ns/1ps
module uart_dbuf_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_stb = 1'b0;
  logic [8:0] wr_data = '0;
  logic       tx_en = 1'b1;
  logic [1:0] cfg_src_sel = 2'd0;
  logic [7:0] cfg_div = 8'd0;
  logic [1:0] cfg_char_len = 2'd1;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_cts_en = 1'b0;
  logic       cfg_irq_sel = 1'b0;
  logic       ext_clk = 1'b0;
  logic       cts_n = 1'b0;
  logic       txd, buf_empty, tx_busy, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_dbuf_tx dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .tx_en(tx_en),
    .cfg_src_sel(cfg_src_sel), .cfg_div(cfg_div), .cfg_char_len(cfg_char_len),
    .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop), .cfg_cts_en(cfg_cts_en),
    .cfg_irq_sel(cfg_irq_sel), .ext_clk(ext_clk), .cts_n(cts_n),
    .txd(txd), .buf_empty(buf_empty), .tx_busy(tx_busy), .irq(irq));

  // external source clock: period of 6 system cycles
  initial forever begin
    repeat (3) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_frame(input logic [8:0] d, input int lcode, input int par,
                                    input bit two, output logic [12:0] b, output int f);
    int  len;
    logic p;
    len = (lcode == 0) ? 7 : (lcode == 2) ? 9 : 8;
    b = '1; b[0] = 1'b0; p = 1'b0;
    for (int i = 0; i < len; i++) begin b[1+i] = d[i]; p = p ^ d[i]; end
    f = 1 + len;
    if (par == 1) begin b[f] = p;  f++; end
    if (par == 2) begin b[f] = ~p; f++; end
    f = f + (two ? 2 : 1);
  endfunction

  task automatic wr(input logic [8:0] d);
    @(negedge clk); wr_stb = 1'b1; wr_data = d;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic idle_watch(input int n, input string tag);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk(lows == 0, tag, lows, 0);
  endtask

  // act: 0 none, 1 raise cts_n mid-frame, 2 drop tx_en and write mid-frame
  task automatic cap(input int bt, input int f, input bit wait_start, input int act,
                     input logic [8:0] act_data, output logic [12:0] got);
    int t = 0;
    got = '1;
    if (wait_start) begin
      while (txd !== 1'b0 && t < 40000) begin @(negedge clk); t++; end
      chk(t < 40000, "R6 frame start timeout", t, 0);
    end
    if (!cfg_irq_sel) begin
      chk(irq === 1'b1, "R8 irq at buffer load", irq, 1);
      @(negedge clk);
      chk(irq === 1'b0, "R8 irq one cycle", irq, 0);
      repeat (bt/2 - 1) @(negedge clk);
    end else begin
      repeat (bt/2) @(negedge clk);
    end
    for (int i = 0; i < f; i++) begin
      if (i > 0) repeat (bt) @(negedge clk);
      got[i] = txd;
      if (i == 1 && act == 1) cts_n = 1'b1;
      if (i == 1 && act == 2) begin tx_en = 1'b0; wr_data = act_data; wr_stb = 1'b1; end
      if (i == 2 && act == 2) wr_stb = 1'b0;
    end
    if (cfg_irq_sel) begin
      repeat (bt/2 - 1) @(negedge clk);
      chk(irq === 1'b0, "R8 no irq before frame end", irq, 0);
      @(negedge clk);
      chk(irq === 1'b1, "R8 irq at frame end", irq, 1);
    end else begin
      repeat (bt/2) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1 reset txd", txd, 1);
    chk(buf_empty === 1'b1, "R1 reset buf_empty", buf_empty, 1);
    chk(tx_busy === 1'b0, "R1 reset busy", tx_busy, 0);
    chk(irq === 1'b0, "R1 reset irq", irq, 0);
    idle_watch(100, "R1 idle line high");
  endtask

  task automatic t_format(input string tag, input logic [8:0] d, input int lcode,
                          input int par, input bit two);
    logic [12:0] e, g; int f;
    cfg_char_len = 2'(lcode); cfg_parity = 2'(par); cfg_two_stop = two;
    exp_frame(d, lcode, par, two, e, f);
    wr(d);
    cap(16, f, 1, 0, 9'h0, g);
    chk(g == e, tag, int'(g), int'(e));
    idle_watch(20, {tag, " idle after"});
  endtask

  task automatic t_rate(input string tag, input int sel, input int n, input int bt);
    int t = 0, cnt = 0;
    cfg_src_sel = 2'(sel); cfg_div = 8'(n);
    cfg_char_len = 2'd1; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
    wr(9'h0FF);
    while (txd !== 1'b0 && t < 40000) begin @(negedge clk); t++; end
    while (txd === 1'b0 && cnt < 40000) begin @(negedge clk); cnt++; end
    chk(cnt == bt, tag, cnt, bt);
    repeat (9 * bt + bt) @(negedge clk);
    cfg_src_sel = 2'd0; cfg_div = 8'd0;
    repeat (40) @(negedge clk);
  endtask

  task automatic t_b2b();
    logic [12:0] e, g; int f, cnt = 0;
    cfg_char_len = 2'd1; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
    exp_frame(9'h0E1, 1, 0, 0, e, f);
    wr(9'h03C);
    while (buf_empty !== 1'b1 && cnt < 40000) begin @(negedge clk); cnt++; end
    @(negedge clk); wr_stb = 1'b1; wr_data = 9'h0E1;
    @(negedge clk); wr_stb = 1'b0;
    chk(buf_empty === 1'b0, "R7 buffer full during frame", buf_empty, 0);
    cnt = 2;
    while (buf_empty !== 1'b1 && cnt < 40000) begin @(negedge clk); cnt++; end
    chk(cnt == 16 * f, "R7 back-to-back spacing", cnt, 16 * f);
    cap(16, f, 0, 0, 9'h0, g);
    chk(g == e, "R7 second frame content", int'(g), int'(e));
    idle_watch(20, "R7 idle after pair");
  endtask

  task automatic t_cts();
    logic [12:0] e, g; int f;
    cfg_char_len = 2'd1; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
    cfg_cts_en = 1'b1; cts_n = 1'b1;
    wr(9'h05A);
    idle_watch(400, "R6 held by cts_n high");
    chk(buf_empty === 1'b0, "R6 char still buffered", buf_empty, 0);
    exp_frame(9'h05A, 1, 0, 0, e, f);
    cts_n = 1'b0;
    cap(16, f, 1, 0, 9'h0, g);
    chk(g == e, "R6 frame after cts_n low", int'(g), int'(e));
    exp_frame(9'h0C3, 1, 0, 0, e, f);
    wr(9'h0C3);
    cap(16, f, 1, 1, 9'h0, g);
    chk(g == e, "R6 frame not cut by cts_n rise", int'(g), int'(e));
    wr(9'h011);
    idle_watch(400, "R6 next frame held");
    exp_frame(9'h011, 1, 0, 0, e, f);
    cts_n = 1'b0;
    cap(16, f, 1, 0, 9'h0, g);
    chk(g == e, "R6 held frame sent", int'(g), int'(e));
    cfg_cts_en = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_disable();
    logic [12:0] e, g; int f;
    cfg_char_len = 2'd1; cfg_parity = 2'd0; cfg_two_stop = 1'b0;
    exp_frame(9'h096, 1, 0, 0, e, f);
    wr(9'h096);
    cap(16, f, 1, 2, 9'h03C, g);
    chk(g == e, "R9 frame completes after tx_en low", int'(g), int'(e));
    idle_watch(400, "R9 line idle while disabled");
    chk(buf_empty === 1'b0, "R9 char waits in buffer", buf_empty, 0);
    exp_frame(9'h03C, 1, 0, 0, e, f);
    tx_en = 1'b1;
    cap(16, f, 1, 0, 9'h0, g);
    chk(g == e, "R9 frame after re-enable", int'(g), int'(e));
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_format("R2 8N1 bit order", 9'h0A5, 1, 0, 0);
    t_format("R2 7-bit drops upper bits", 9'h1B5, 0, 0, 0);
    t_format("R3 7E1 even parity", 9'h035, 0, 1, 0);
    t_format("R3 8O1 odd parity zero data", 9'h000, 1, 2, 0);
    t_format("R5 9O2 two stop bits", 9'h1C3, 2, 2, 1);
    t_format("R5 8E2 two stop bits", 9'h07F, 1, 1, 1);
    cfg_irq_sel = 1'b1;
    t_format("R8 end-of-frame irq 8N1", 9'h03E, 1, 0, 0);
    t_format("R8 end-of-frame irq 9N2", 9'h155, 2, 0, 1);
    cfg_irq_sel = 1'b0;
    t_rate("R4 fast n=3", 0, 3, 64);
    t_rate("R4 div8 n=1", 1, 1, 256);
    t_rate("R4 div32 n=0", 2, 0, 512);
    t_rate("R4 external n=0", 3, 0, 96);
    t_b2b();
    t_cts();
    t_disable();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule